// File: doc/BRIEF.md
# Bus to CompactFlash Microprocessor Port Bridge

This block sits between a single-beat, memory-mapped bus slave port and the microprocessor port of an external CompactFlash controller chip. Each bus select starts exactly one device access: the bus-side logic picks the byte or halfword lane that the address names and holds the request stable. It then flips a request toggle. That toggle is synchronized into the slower device clock, where a five-state machine drives the device pins. When the access ends, a completion toggle travels back to the bus clock and the block raises a one-cycle acknowledge. For reads, the acknowledge carries the captured data.

The block has no registers of its own. The seven bus offset bits go straight onto the device address, so the window that the surrounding decoder assigns must be at least 128 bytes, a power of two in size, and aligned to that size. A parameter selects an 8-bit or a 16-bit device data path. Every pin toward the device comes from a register clocked by the device clock. The device clock must not run faster than the bus clock. The device interrupt goes straight through to the interrupt output.

Top module: `cf_mpu_bridge`

## Requirements
- R1: After reset the device data enable `dev_d_t` is all ones (bus released), `dev_d_o` is zero, `dev_ce_n`, `dev_oe_n` and `dev_we_n` are 1, and `bus_ack` is 0.
- R2: Each assertion of `bus_cs` produces exactly one `bus_ack` pulse of one bus clock and at most one device access; the master holds the request until the acknowledge.
- R3: During an access `dev_addr` equals the full 7-bit `bus_addr`, including its lane bits.
- R4: With a 16-bit device path, `bus_addr[1]`=0 selects bus bits 31:16 and `bus_addr[1]`=1 selects bits 15:0; the higher byte of the lane (for example bits 31:24) maps to device data 15:8, with no byte swap.
- R5: With an 8-bit device path, `bus_addr[1:0]` values 0, 1, 2 and 3 select bus bits 31:24, 23:16, 15:8 and 7:0 respectively.
- R6: The chip enable falls one device clock before the strobe, the strobe (`dev_oe_n` for reads, `dev_we_n` for writes) stays low exactly two device clocks, the chip enable stays low one device clock after the strobe rises, and the two strobes are never low together.
- R7: `dev_d_t` is all zeros whenever the write strobe is low and all ones whenever the read strobe is low.
- R8: A read returns the device data present during the last strobe clock, placed in the selected lane with every other bit of `bus_rdata` zero.
- R9: `irq_out` follows `dev_irq` without any clocking.
- R10: While `bus_cs` is low, no device access takes place and the chip enable stays high.
- R11: Byte enables are active high, with `bus_be[3]` covering bits 31:24 and `bus_be[0]` covering bits 7:0. When no enable covers the selected lane, the block acknowledges without any device access, and a read then returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus clock |
| bus_cs | input | 1 | Request select, held until acknowledge |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 7 | Offset inside the window |
| bus_be | input | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with the acknowledge |
| bus_ack | output | 1 | One-cycle completion pulse |
| dev_clk | input | 1 | Device port clock |
| dev_rst | input | 1 | Synchronous active-high reset, device clock |
| dev_addr | output | 7 | Device address |
| dev_ce_n | output | 1 | Chip enable, active low |
| dev_oe_n | output | 1 | Read strobe, active low |
| dev_we_n | output | 1 | Write strobe, active low |
| dev_d_i | input | MW | Data from the device pads |
| dev_d_o | output | MW | Data toward the device pads |
| dev_d_t | output | MW | Pad enable, 1 = released |
| dev_irq | input | 1 | Device interrupt |
| irq_out | output | 1 | Interrupt toward the processor |

## Verification
The bench runs one 16-bit and one 8-bit instance against small device memory models. It targets lane placement, because a design that swapped bytes or picked the wrong lane would store mirrored values and return data in the wrong bit positions. It measures the strobe width and the enable margins on every access, since an off-by-one in the strobe counter would shorten the read window. It also aims requests whose byte enables miss the addressed lane at the block, because a design that forwarded them would corrupt device locations. Finally, it idles the select line to catch a lost toggle edge, which would start a phantom access or hang the acknowledge.

// File: rtl/cfmb_pkg.sv
package cfmb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } dev_state_e;
endpackage

// File: rtl/cfmb_tgl_sync.sv
module cfmb_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[LEN-2:0], tgl_in};
  end

  assign pulse = sh[LEN-1] ^ sh[LEN-2];
endmodule

// File: rtl/cfmb_bus_side.sv
module cfmb_bus_side #(
  parameter int DW = 32,
  parameter int MW = 16,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rnw,
  input  logic [AW-1:0] addr,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ack,
  input  logic          done_pulse,
  input  logic [MW-1:0] dev_rd,
  output logic          req_tgl,
  output logic [AW-1:0] h_addr,
  output logic [MW-1:0] h_wdata,
  output logic          h_rnw
);
  localparam int LANES = DW / MW;
  localparam int BPL   = MW / 8;
  localparam int OFF   = $clog2(BPL);
  localparam int LSW   = $clog2(LANES);

  logic [LSW-1:0] lane, h_lane;
  logic [MW-1:0]  sel_wd;
  logic           sel_be;
  logic [DW-1:0]  rd_place;
  logic           busy;

  assign lane = addr[OFF +: LSW];

  always_comb begin
    sel_wd = '0;
    sel_be = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (lane == LSW'(i)) begin
        sel_wd = wdata[(LANES-1-i)*MW +: MW];
        sel_be = |be[(LANES-1-i)*BPL +: BPL];
      end
    end
  end

  always_comb begin
    rd_place = '0;
    for (int i = 0; i < LANES; i++) begin
      if (h_lane == LSW'(i)) rd_place[(LANES-1-i)*MW +: MW] = dev_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      ack     <= 1'b0;
      rdata   <= '0;
      req_tgl <= 1'b0;
      h_addr  <= '0;
      h_wdata <= '0;
      h_rnw   <= 1'b1;
      h_lane  <= '0;
    end else begin
      ack <= 1'b0;
      if (busy) begin
        if (done_pulse) begin
          busy  <= 1'b0;
          ack   <= 1'b1;
          rdata <= h_rnw ? rd_place : '0;
        end
      end else if (cs && !ack) begin
        if (sel_be) begin
          busy    <= 1'b1;
          req_tgl <= ~req_tgl;
          h_addr  <= addr;
          h_wdata <= sel_wd;
          h_rnw   <= rnw;
          h_lane  <= lane;
        end else begin
          ack   <= 1'b1;
          rdata <= '0;
        end
      end
    end
  end

  assert_ack_single_R2: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_done_needs_request_R2: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> busy);
endmodule

// File: rtl/cfmb_dev_fsm.sv
module cfmb_dev_fsm
  import cfmb_pkg::*;
#(
  parameter int MW         = 16,
  parameter int AW         = 7,
  parameter int STROBE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] h_addr,
  input  logic [MW-1:0] h_wdata,
  input  logic          h_rnw,
  output logic [AW-1:0] dev_addr,
  output logic          dev_ce_n,
  output logic          dev_oe_n,
  output logic          dev_we_n,
  input  logic [MW-1:0] dev_d_i,
  output logic [MW-1:0] dev_d_o,
  output logic [MW-1:0] dev_d_t,
  output logic [MW-1:0] rd_hold,
  output logic          done_tgl
);
  localparam int CW = $clog2(STROBE_CYC + 1);

  dev_state_e    st;
  logic [CW-1:0] cnt;
  logic          rnw_q;
  logic [MW-1:0] din_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      rnw_q    <= 1'b1;
      din_q    <= '0;
      dev_addr <= '0;
      dev_ce_n <= 1'b1;
      dev_oe_n <= 1'b1;
      dev_we_n <= 1'b1;
      dev_d_o  <= '0;
      dev_d_t  <= '1;
      rd_hold  <= '0;
      done_tgl <= 1'b0;
    end else begin
      din_q <= dev_d_i;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st       <= ST_SETUP;
            dev_addr <= h_addr;
            rnw_q    <= h_rnw;
            dev_ce_n <= 1'b0;
            if (!h_rnw) begin
              dev_d_o <= h_wdata;
              dev_d_t <= '0;
            end
          end
        end
        ST_SETUP: begin
          st  <= ST_STROBE;
          cnt <= '0;
          if (rnw_q) dev_oe_n <= 1'b0;
          else       dev_we_n <= 1'b0;
        end
        ST_STROBE: begin
          if (cnt == CW'(STROBE_CYC - 1)) begin
            st       <= ST_HOLD;
            dev_oe_n <= 1'b1;
            dev_we_n <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          st       <= ST_DONE;
          dev_ce_n <= 1'b1;
          dev_d_t  <= '1;
          if (rnw_q) rd_hold <= din_q;
          done_tgl <= ~done_tgl;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(!dev_oe_n && !dev_we_n));

  assert_strobe_inside_ce_R6: assert property (@(posedge clk) disable iff (rst)
    (!dev_oe_n || !dev_we_n) |-> !dev_ce_n);

  assert_write_strobe_two_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_we_n) |-> ($past(dev_we_n) == 1'b0 && $past(dev_we_n, 2) == 1'b0));

  assert_read_strobe_two_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_oe_n) |-> ($past(dev_oe_n) == 1'b0 && $past(dev_oe_n, 2) == 1'b0));

  assert_no_drive_on_read_R7: assert property (@(posedge clk) disable iff (rst)
    !dev_oe_n |-> (&dev_d_t));

  assert_drive_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    !dev_we_n |-> (dev_d_t == '0));
endmodule

// File: rtl/cf_mpu_bridge.sv
module cf_mpu_bridge #(
  parameter int DW          = 32,
  parameter int MW          = 16,
  parameter int DEV_AW      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int STROBE_CYC  = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              bus_cs,
  input  logic              bus_rnw,
  input  logic [DEV_AW-1:0] bus_addr,
  input  logic [DW/8-1:0]   bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ack,
  input  logic              dev_clk,
  input  logic              dev_rst,
  output logic [DEV_AW-1:0] dev_addr,
  output logic              dev_ce_n,
  output logic              dev_oe_n,
  output logic              dev_we_n,
  input  logic [MW-1:0]     dev_d_i,
  output logic [MW-1:0]     dev_d_o,
  output logic [MW-1:0]     dev_d_t,
  input  logic              dev_irq,
  output logic              irq_out
);
  logic              req_tgl, req_start;
  logic              done_tgl, done_pulse;
  logic [DEV_AW-1:0] h_addr;
  logic [MW-1:0]     h_wdata, rd_hold;
  logic              h_rnw;

  assign irq_out = dev_irq;

  cfmb_bus_side #(.DW(DW), .MW(MW), .AW(DEV_AW)) u_bus (
    .clk(bus_clk), .rst(bus_rst), .cs(bus_cs), .rnw(bus_rnw),
    .addr(bus_addr), .be(bus_be), .wdata(bus_wdata),
    .rdata(bus_rdata), .ack(bus_ack),
    .done_pulse(done_pulse), .dev_rd(rd_hold),
    .req_tgl(req_tgl), .h_addr(h_addr), .h_wdata(h_wdata), .h_rnw(h_rnw)
  );

  cfmb_tgl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(dev_clk), .rst(dev_rst), .tgl_in(req_tgl), .pulse(req_start)
  );

  cfmb_dev_fsm #(.MW(MW), .AW(DEV_AW), .STROBE_CYC(STROBE_CYC)) u_fsm (
    .clk(dev_clk), .rst(dev_rst), .start(req_start),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rnw(h_rnw),
    .dev_addr(dev_addr), .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n),
    .dev_we_n(dev_we_n), .dev_d_i(dev_d_i), .dev_d_o(dev_d_o),
    .dev_d_t(dev_d_t), .rd_hold(rd_hold), .done_tgl(done_tgl)
  );

  cfmb_tgl_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(bus_clk), .rst(bus_rst), .tgl_in(done_tgl), .pulse(done_pulse)
  );
endmodule

// File: tb/cf_mpu_bridge_test.sv
module cf_mpu_bridge_test;
  logic bclk = 1'b0;
  logic dclk = 1'b0;
  logic brst = 1'b1;
  logic drst = 1'b1;
  always #4  bclk = ~bclk;
  always #15 dclk = ~dclk;

  int n_chk = 0;
  int n_bad = 0;

  // 16-bit instance
  logic        b_cs = 0, b_rnw = 1;
  logic [6:0]  b_addr = '0;
  logic [3:0]  b_be = '0;
  logic [31:0] b_wd = '0, b_rd;
  logic        b_ack;
  logic [6:0]  d16_addr;
  logic        d16_ce_n, d16_oe_n, d16_we_n;
  logic [15:0] d16_di, d16_do, d16_t;
  logic        irq_in = 0, irq_o;

  // 8-bit instance
  logic        c_cs = 0, c_rnw = 1;
  logic [6:0]  c_addr = '0;
  logic [3:0]  c_be = '0;
  logic [31:0] c_wd = '0, c_rd;
  logic        c_ack;
  logic [6:0]  d8_addr;
  logic        d8_ce_n, d8_oe_n, d8_we_n;
  logic [7:0]  d8_di, d8_do, d8_t;
  logic        irq8_o;

  cf_mpu_bridge #(.MW(16)) uut (
    .bus_clk(bclk), .bus_rst(brst), .bus_cs(b_cs), .bus_rnw(b_rnw),
    .bus_addr(b_addr), .bus_be(b_be), .bus_wdata(b_wd), .bus_rdata(b_rd),
    .bus_ack(b_ack), .dev_clk(dclk), .dev_rst(drst), .dev_addr(d16_addr),
    .dev_ce_n(d16_ce_n), .dev_oe_n(d16_oe_n), .dev_we_n(d16_we_n),
    .dev_d_i(d16_di), .dev_d_o(d16_do), .dev_d_t(d16_t),
    .dev_irq(irq_in), .irq_out(irq_o)
  );

  cf_mpu_bridge #(.MW(8)) uut8 (
    .bus_clk(bclk), .bus_rst(brst), .bus_cs(c_cs), .bus_rnw(c_rnw),
    .bus_addr(c_addr), .bus_be(c_be), .bus_wdata(c_wd), .bus_rdata(c_rd),
    .bus_ack(c_ack), .dev_clk(dclk), .dev_rst(drst), .dev_addr(d8_addr),
    .dev_ce_n(d8_ce_n), .dev_oe_n(d8_oe_n), .dev_we_n(d8_we_n),
    .dev_d_i(d8_di), .dev_d_o(d8_do), .dev_d_t(d8_t),
    .dev_irq(1'b0), .irq_out(irq8_o)
  );

  // device memory models
  logic [15:0] mem16 [0:127];
  logic [7:0]  mem8  [0:127];
  assign d16_di = (!d16_ce_n && !d16_oe_n) ? mem16[d16_addr] : 16'h0;
  assign d8_di  = (!d8_ce_n && !d8_oe_n) ? mem8[d8_addr] : 8'h0;

  always @(posedge dclk) begin
    if (drst) begin
      for (int i = 0; i < 128; i++) begin
        mem16[i] <= 16'h0;
        mem8[i]  <= 8'h0;
      end
    end else begin
      if (!d16_ce_n && !d16_we_n) mem16[d16_addr] <= d16_do;
      if (!d8_ce_n && !d8_we_n)   mem8[d8_addr]  <= d8_do;
    end
  end

  // pin monitor on the 16-bit device port
  int   acc_cnt = 0, ce_cnt = 0, cur_len = 0, last_len = 0;
  int   setup_bad = 0, hold_bad = 0, wr_drive_bad = 0, rd_float_bad = 0, wr_seen = 0;
  logic prev_strobe = 1'b0, prev_ce_n = 1'b1;
  logic [6:0] last_addr = '0;
  logic strobe;
  assign strobe = !d16_oe_n || !d16_we_n;

  always @(posedge dclk) begin
    if (!drst) begin
      if (!d16_ce_n) ce_cnt <= ce_cnt + 1;
      if (strobe && !prev_strobe) begin
        acc_cnt   <= acc_cnt + 1;
        cur_len   <= 1;
        last_addr <= d16_addr;
        if (prev_ce_n) setup_bad <= setup_bad + 1;
      end else if (strobe) begin
        cur_len <= cur_len + 1;
      end
      if (!strobe && prev_strobe) begin
        last_len <= cur_len;
        if (d16_ce_n) hold_bad <= hold_bad + 1;
      end
      if (!d16_we_n) begin
        wr_seen <= wr_seen + 1;
        if (d16_t != 16'h0) wr_drive_bad <= wr_drive_bad + 1;
      end
      if (!d16_oe_n && d16_t != 16'hFFFF) rd_float_bad <= rd_float_bad + 1;
    end
    prev_strobe <= strobe;
    prev_ce_n   <= d16_ce_n;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xfer(input bit w8, input bit rnw, input logic [6:0] a,
                      input logic [3:0] be, input logic [31:0] wd,
                      output logic [31:0] rd);
    int n;
    logic ak;
    @(negedge bclk);
    if (w8) begin c_rnw = rnw; c_addr = a; c_be = be; c_wd = wd; c_cs = 1'b1; end
    else    begin b_rnw = rnw; b_addr = a; b_be = be; b_wd = wd; b_cs = 1'b1; end
    n = 0;
    do begin
      @(negedge bclk);
      n++;
      ak = w8 ? c_ack : b_ack;
    end while (!ak && n < 400);
    if (!ak) check("R2 acknowledge arrives", 32'd0, 32'd1);
    rd = w8 ? c_rd : b_rd;
    if (w8) c_cs = 1'b0; else b_cs = 1'b0;
    @(negedge bclk);
    check("R2 acknowledge lasts one cycle", {31'd0, (w8 ? c_ack : b_ack)}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 pad enable released 16", {16'd0, d16_t}, 32'h0000FFFF);
    check("R1 pad enable released 8", {24'd0, d8_t}, 32'h000000FF);
    check("R1 data out zero", {16'd0, d16_do}, 32'h0);
    check("R1 control pins idle", {29'd0, d16_ce_n, d16_oe_n, d16_we_n}, 32'h7);
    check("R1 no acknowledge", {31'd0, b_ack}, 32'h0);
  endtask

  task automatic t_irq;
    irq_in = 1'b1; #1;
    check("R9 interrupt high", {31'd0, irq_o}, 32'd1);
    irq_in = 1'b0; #1;
    check("R9 interrupt low", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_lanes16;
    logic [31:0] rd;
    int a0;
    a0 = acc_cnt;
    xfer(0, 0, 7'h04, 4'b1100, 32'hA55A_0000, rd);
    check("R2 one device access per select", acc_cnt - a0, 32'd1);
    check("R4 upper lane stored", {16'd0, mem16[4]}, 32'h0000A55A);
    check("R4 bits 31:24 on device 15:8", {24'd0, mem16[4][15:8]}, 32'hA5);
    check("R6 strobe two device clocks", last_len, 32'd2);
    xfer(0, 0, 7'h06, 4'b0011, 32'hBEEF_1234, rd);
    check("R4 lower lane stored", {16'd0, mem16[6]}, 32'h00001234);
    xfer(0, 1, 7'h04, 4'b1100, 32'h0, rd);
    check("R8 read upper lane", rd, 32'hA55A_0000);
    check("R6 read strobe two device clocks", last_len, 32'd2);
    xfer(0, 1, 7'h06, 4'b0011, 32'h0, rd);
    check("R8 read lower lane, rest zero", rd, 32'h0000_1234);
    check("R6 enable margins", setup_bad + hold_bad, 32'd0);
  endtask

  task automatic t_addr;
    logic [31:0] rd;
    xfer(0, 0, 7'h7E, 4'b0011, 32'h0000_C3C3, rd);
    check("R3 device address pin", {25'd0, last_addr}, 32'h7E);
    check("R3 top location written", {16'd0, mem16[7'h7E]}, 32'h0000C3C3);
  endtask

  task automatic t_lanes8;
    logic [31:0] rd, wd;
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      v  = 8'(8'h11 * (i + 1));
      wd = 32'hEEEE_EEEE;
      wd[(3-i)*8 +: 8] = v;
      xfer(1, 0, 7'(7'h10 + i), 4'(4'b1000 >> i), wd, rd);
      check("R5 byte lane stored", {24'd0, mem8[7'h10 + i]}, {24'd0, v});
    end
    for (int i = 0; i < 4; i++) begin
      v = 8'(8'h11 * (i + 1));
      xfer(1, 1, 7'(7'h10 + i), 4'(4'b1000 >> i), 32'h0, rd);
      check("R5 byte lane read back", rd, 32'(v) << ((3 - i) * 8));
    end
  endtask

  task automatic t_null;
    logic [31:0] rd;
    int a0;
    a0 = acc_cnt;
    xfer(0, 0, 7'h08, 4'b0011, 32'hDEAD_BEEF, rd);
    repeat (20) @(negedge bclk);
    check("R11 missed lane write has no access", acc_cnt - a0, 32'd0);
    check("R11 device location untouched", {16'd0, mem16[8]}, 32'h0);
    xfer(0, 1, 7'h08, 4'b0011, 32'h0, rd);
    repeat (20) @(negedge bclk);
    check("R11 missed lane read returns zero", rd, 32'h0);
    check("R11 missed lane read has no access", acc_cnt - a0, 32'd0);
  endtask

  task automatic t_idle;
    int c0;
    repeat (10) @(negedge bclk);
    c0 = ce_cnt;
    repeat (60) @(negedge bclk);
    check("R10 no access while deselected", ce_cnt - c0, 32'd0);
    check("R10 chip enable high", {31'd0, d16_ce_n}, 32'd1);
  endtask

  task automatic t_direction;
    check("R7 pads driven under write strobe", wr_drive_bad, 32'd0);
    check("R7 write strobe was seen", {31'd0, wr_seen > 0}, 32'd1);
    check("R7 pads released under read strobe", rd_float_bad, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    n_bad++;
    $display("FAIL R2 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge dclk);
    brst = 1'b0;
    drst = 1'b0;
    @(negedge bclk);
    t_reset();
    t_irq();
    t_idle();
    t_lanes16();
    t_addr();
    t_lanes8();
    t_null();
    t_direction();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule